// File: doc/BRIEF.md
# Shared-Prescaler Multi-Channel PWM Generator

This block drives a small group of pulse-width-modulated outputs from one common time base. A programmable divider turns the system clock into a slower local tick. An 8-bit frame counter advances on that tick, so every frame lasts exactly 256 local ticks. Each channel compares the frame counter with its own 8-bit duty value and holds its output high while the counter has not yet passed that value. A channel therefore stays high for the duty value plus one ticks. A duty of zero still gives a one-tick pulse, and a duty of 255 keeps the output high for the whole frame.

The frame length is fixed, so the only way to change the PWM period is to change the shared prescaler. Its 8 bits are split into two 4-bit fields that sit apart in one control word, next to a single enable bit that gates every channel together. Software writes duty and control words through a simple write port. New values are staged and take effect only at the next frame boundary, which keeps every frame whole. Clearing the enable stops the time base and forces all outputs low.

Top module: `pwm_ps_top`

## Requirements
- R1: After reset all outputs are low, the enable is cleared, and every duty and prescaler value is zero. While the enable stays cleared, writing a duty value does not raise any output.
- R2: With prescaler value P, one local tick lasts P+1 clock cycles and one frame lasts 256*(P+1) clock cycles.
- R3: With duty value D and prescaler P, a channel is high for the first (D+1)*(P+1) clock cycles of each frame and low for the rest of the frame.
- R4: Every channel is high during the first local tick of a frame. A channel with duty 0 is low from the second tick until the frame ends.
- R5: A channel with duty 255 is high for the whole frame.
- R6: The control word is at byte address 0x50. Bits 3:0 hold the low nibble of the prescaler, bits 14:11 hold the high nibble, and bit 9 is the common enable.
- R7: The duty value of channel n is at byte address 4*n. Only bits 7:0 of the written data are kept.
- R8: A duty or prescaler write made during a frame does not change that frame. The new value applies from the next frame boundary.
- R9: One clock after a control write clears the enable, all outputs are low and stay low. One clock after a write sets the enable, a new frame starts at count 0 using the staged values.
- R10: Writes to any address other than the duty addresses of existing channels and 0x50 change nothing.
- R11: Channels share the time base but hold independent duty values, so each one produces its own pulse width within the same frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_addr | input | 8 | Byte address of the register written |
| wr_data | input | 32 | Write data |
| pwm_out | output | 4 | One PWM output per channel |

## Verification
The assertions check the time base on every cycle. The frame counter moves only on a local tick and steps by exactly one. The staged prescaler and duty values stay fixed except at a frame boundary or while halted. Outputs are low whenever the time base is halted, all outputs are high at count zero, and a full-scale duty keeps its output high. Pulse widths in clock cycles, the split prescaler field positions, address decoding, the one-cycle enable latency and the deferral of mid-frame writes can only be shown by the bench. It counts high cycles over whole frames for swept duty and prescaler values and compares them with (D+1)*(P+1).

// File: rtl/pwm_ps_pkg.sv
`timescale 1ns/1ps
package pwm_ps_pkg;

   // byte distance between consecutive duty registers
   localparam int unsigned REG_STRIDE = 4;

   // run state of the shared time base
   typedef enum logic {
      PH_HALT = 1'b0,
      PH_RUN  = 1'b1
   } run_phase_e;

   function automatic int unsigned duty_offset(input int unsigned chan);
      return chan * REG_STRIDE;
   endfunction

endpackage

// File: rtl/pwm_ps_regs.sv
`timescale 1ns/1ps
module pwm_ps_regs
   import pwm_ps_pkg::*;
#(
   parameter int unsigned NCH       = 4,
   parameter int unsigned CNT_W     = 8,
   parameter int unsigned PS_W      = 8,
   parameter int unsigned ADDR_W    = 8,
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned CTRL_ADDR = 'h50,
   parameter int unsigned EN_BIT    = 9,
   parameter int unsigned PS_LO_LSB = 0,
   parameter int unsigned PS_HI_LSB = 11
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   wr_en,
   input  logic [ADDR_W-1:0]      wr_addr,
   input  logic [DATA_W-1:0]      wr_data,
   output logic [NCH*CNT_W-1:0]   duty_stage,
   output logic [PS_W-1:0]        ps_stage,
   output logic                   en_stage
);

   localparam int unsigned HALF_W = PS_W / 2;
   localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_ADDR);

   logic ctrl_hit;
   logic unused_wdata;

   assign ctrl_hit     = wr_en && (wr_addr == CTRL_A);
   assign unused_wdata = ^wr_data;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ps_stage <= '0;
         en_stage <= 1'b0;
      end else if (ctrl_hit) begin
         ps_stage <= {wr_data[PS_HI_LSB +: HALF_W], wr_data[PS_LO_LSB +: HALF_W]};
         en_stage <= wr_data[EN_BIT];
      end
   end

   for (genvar n = 0; n < NCH; n++) begin : g_duty
      localparam logic [ADDR_W-1:0] DUTY_A = ADDR_W'(duty_offset(n));
      logic hit;
      assign hit = wr_en && (wr_addr == DUTY_A);
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            duty_stage[n*CNT_W +: CNT_W] <= '0;
         else if (hit)
            duty_stage[n*CNT_W +: CNT_W] <= wr_data[CNT_W-1:0];
      end
   end

endmodule

// File: rtl/pwm_ps_timebase.sv
`timescale 1ns/1ps
module pwm_ps_timebase
   import pwm_ps_pkg::*;
#(
   parameter int unsigned CNT_W = 8,
   parameter int unsigned PS_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en_req,
   input  logic [PS_W-1:0]   ps_stage,
   output logic              run,
   output logic              tick,
   output logic              frame_end,
   output logic              load,
   output logic [CNT_W-1:0]  frame_cnt,
   output logic [PS_W-1:0]   ps_act
);

   localparam logic [CNT_W-1:0] CNT_LAST = '1;

   run_phase_e       phase_q;
   logic [PS_W-1:0]  div_cnt;

   assign run       = (phase_q == PH_RUN);
   assign tick      = run && (div_cnt == ps_act);
   assign frame_end = tick && (frame_cnt == CNT_LAST);
   assign load      = !run || frame_end;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q   <= PH_HALT;
         div_cnt   <= '0;
         frame_cnt <= '0;
         ps_act    <= '0;
      end else begin
         phase_q <= en_req ? PH_RUN : PH_HALT;
         if (!run) begin
            div_cnt   <= '0;
            frame_cnt <= '0;
         end else if (tick) begin
            div_cnt   <= '0;
            frame_cnt <= frame_cnt + 1'b1;
         end else begin
            div_cnt   <= div_cnt + 1'b1;
         end
         if (load)
            ps_act <= ps_stage;
      end
   end

endmodule

// File: rtl/pwm_ps_chan.sv
`timescale 1ns/1ps
module pwm_ps_chan #(
   parameter int unsigned CNT_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              run,
   input  logic [CNT_W-1:0]  duty_stage,
   input  logic [CNT_W-1:0]  frame_cnt,
   output logic [CNT_W-1:0]  duty_act,
   output logic              pwm
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         duty_act <= '0;
      else if (load)
         duty_act <= duty_stage;
   end

   assign pwm = run && (frame_cnt <= duty_act);

endmodule

// File: rtl/pwm_ps_top.sv
`timescale 1ns/1ps
module pwm_ps_top #(
   parameter int unsigned NCH       = 4,
   parameter int unsigned CNT_W     = 8,
   parameter int unsigned PS_W      = 8,
   parameter int unsigned ADDR_W    = 8,
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned CTRL_ADDR = 'h50,
   parameter int unsigned EN_BIT    = 9,
   parameter int unsigned PS_LO_LSB = 0,
   parameter int unsigned PS_HI_LSB = 11
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [ADDR_W-1:0]  wr_addr,
   input  logic [DATA_W-1:0]  wr_data,
   output logic [NCH-1:0]     pwm_out
);

   localparam int unsigned HALF_W = PS_W / 2;

   if (NCH < 1 || NCH > 16) begin : g_bad_nch
      $error("pwm_ps_top: NCH out of range");
   end
   if (PS_W < 2 || (PS_W % 2) != 0) begin : g_bad_psw
      $error("pwm_ps_top: PS_W must be even and at least 2");
   end
   if (CNT_W < 2 || CNT_W > DATA_W) begin : g_bad_cnt
      $error("pwm_ps_top: CNT_W out of range");
   end
   if (PS_LO_LSB + HALF_W > PS_HI_LSB || PS_HI_LSB + HALF_W > DATA_W) begin : g_bad_fields
      $error("pwm_ps_top: prescaler fields overlap or exceed the data word");
   end
   if ((EN_BIT >= PS_LO_LSB && EN_BIT < PS_LO_LSB + HALF_W) ||
       (EN_BIT >= PS_HI_LSB && EN_BIT < PS_HI_LSB + HALF_W) || EN_BIT >= DATA_W) begin : g_bad_en
      $error("pwm_ps_top: enable bit collides with a prescaler field");
   end
   if (NCH * pwm_ps_pkg::REG_STRIDE > CTRL_ADDR) begin : g_bad_map
      $error("pwm_ps_top: duty registers reach the control address");
   end

   logic [NCH*CNT_W-1:0] duty_stage;
   logic [NCH*CNT_W-1:0] duty_act_all;
   logic [PS_W-1:0]      ps_stage;
   logic [PS_W-1:0]      ps_act;
   logic                 en_stage;
   logic                 run;
   logic                 tick;
   logic                 frame_end;
   logic                 load;
   logic [CNT_W-1:0]     frame_cnt;

   pwm_ps_regs #(
      .NCH(NCH), .CNT_W(CNT_W), .PS_W(PS_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
      .CTRL_ADDR(CTRL_ADDR), .EN_BIT(EN_BIT), .PS_LO_LSB(PS_LO_LSB), .PS_HI_LSB(PS_HI_LSB)
   ) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (wr_en),
      .wr_addr    (wr_addr),
      .wr_data    (wr_data),
      .duty_stage (duty_stage),
      .ps_stage   (ps_stage),
      .en_stage   (en_stage)
   );

   pwm_ps_timebase #(.CNT_W(CNT_W), .PS_W(PS_W)) u_tb (
      .clk       (clk),
      .rst_n     (rst_n),
      .en_req    (en_stage),
      .ps_stage  (ps_stage),
      .run       (run),
      .tick      (tick),
      .frame_end (frame_end),
      .load      (load),
      .frame_cnt (frame_cnt),
      .ps_act    (ps_act)
   );

   for (genvar n = 0; n < NCH; n++) begin : g_chan
      pwm_ps_chan #(.CNT_W(CNT_W)) u_chan (
         .clk        (clk),
         .rst_n      (rst_n),
         .load       (load),
         .run        (run),
         .duty_stage (duty_stage[n*CNT_W +: CNT_W]),
         .frame_cnt  (frame_cnt),
         .duty_act   (duty_act_all[n*CNT_W +: CNT_W]),
         .pwm        (pwm_out[n])
      );
   end

endmodule

// File: rtl/pwm_ps_chk.sv
`timescale 1ns/1ps
module pwm_ps_chk #(
   parameter int unsigned NCH   = 4,
   parameter int unsigned CNT_W = 8,
   parameter int unsigned PS_W  = 8
) (
   input logic               clk,
   input logic               rst_n,
   input logic               run,
   input logic               tick,
   input logic               frame_end,
   input logic [CNT_W-1:0]   cnt,
   input logic [PS_W-1:0]    ps_act,
   input logic [NCH*CNT_W-1:0] duty_act,
   input logic [NCH-1:0]     pwm_out
);

   // R9: halted time base drives every output low
   assert_halt_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !run |-> (pwm_out == '0));

   // R4: first tick of a frame is high on every channel
   assert_frame_start_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (run && cnt == '0) |-> (&pwm_out));

   // R2: counter holds between ticks
   assert_cnt_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !tick) |=> $stable(cnt));

   // R2: counter steps by one on each tick
   assert_cnt_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (run && tick) |=> (cnt == CNT_W'($past(cnt) + 1'b1)));

   // R8: staged values stay put inside a frame
   assert_duty_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !frame_end) |=> $stable(duty_act));

   assert_ps_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !frame_end) |=> $stable(ps_act));

   for (genvar n = 0; n < NCH; n++) begin : g_full
      // R5: full-scale duty never drops
      assert_full_duty_R5: assert property (@(posedge clk) disable iff (!rst_n)
         (run && duty_act[n*CNT_W +: CNT_W] == '1) |-> pwm_out[n]);
   end

endmodule

bind pwm_ps_top pwm_ps_chk #(.NCH(NCH), .CNT_W(CNT_W), .PS_W(PS_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .run       (run),
   .tick      (tick),
   .frame_end (frame_end),
   .cnt       (frame_cnt),
   .ps_act    (ps_act),
   .duty_act  (duty_act_all),
   .pwm_out   (pwm_out)
);

// File: tb/sim_pwm_ps_top.sv
`timescale 1ns/1ps
module sim_pwm_ps_top;

   localparam int NCH = 4;
   localparam logic [7:0] CTRL = 8'h50;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [7:0]  wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic [NCH-1:0] pwm_out;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   pwm_ps_top u0 (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .pwm_out (pwm_out)
   );

   task automatic check(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] ctrl_word(input bit en, input int ps);
      return (32'(en) << 9) | (32'((ps >> 4) & 15) << 11) | 32'(ps & 15);
   endfunction

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   // stage duties and start a fresh frame with prescaler ps
   task automatic start(input int ps, input int duty [NCH]);
      wr(CTRL, ctrl_word(1'b0, 0));
      for (int n = 0; n < NCH; n++) wr(8'(4*n), 32'(duty[n]));
      wr(CTRL, ctrl_word(1'b1, ps));
   endtask

   // sample one whole frame; optional write at sample index mid
   task automatic run_frame(input int ps, input int mid, input logic [7:0] ma,
                            input logic [31:0] md, output int hi [NCH],
                            output int first, output int second);
      for (int n = 0; n < NCH; n++) hi[n] = 0;
      first = 0; second = 0;
      for (int i = 0; i < 256*(ps+1); i++) begin
         @(negedge clk);
         if (i == mid + 1) wr_en = 1'b0;
         for (int n = 0; n < NCH; n++) hi[n] += int'(pwm_out[n]);
         if (i == 0) first = int'(pwm_out);
         if (i == ps + 1) second = int'(pwm_out);
         if (i == mid) begin wr_en = 1'b1; wr_addr = ma; wr_data = md; end
      end
   endtask

   task automatic check_frame(input string tag, input int ps, input int duty [NCH],
                              input int hi [NCH], input int first, input int second);
      int exp2 = 0;
      for (int n = 0; n < NCH; n++) begin
         check($sformatf("%s R3 ch%0d ps%0d", tag, n, ps), hi[n], (duty[n]+1)*(ps+1));
         if (duty[n] != 0) exp2 |= (1 << n);
      end
      check($sformatf("%s R4 first tick", tag), first, (1 << NCH) - 1);
      check($sformatf("%s R4 second tick", tag), second, exp2);
   endtask

   initial begin
      repeat (180000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected finish");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      int hi [NCH];
      int f, s;
      int duty [NCH];
      int pss [5] = '{1, 2, 15, 17, 48};

      // R1: reset state
      repeat (3) @(negedge clk);
      check("R1 out in reset", int'(pwm_out), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 out after reset", int'(pwm_out), 0);
      wr(8'h00, 32'hFF);
      repeat (4) @(negedge clk);
      check("R1 disabled duty write", int'(pwm_out), 0);

      // R3 R11: duty sweep with prescaler 0
      for (int k = 0; k < 16; k++) begin
         int d = k * 17;
         duty = '{d, 255 - d, (d * 3) & 255, (d + 100) & 255};
         start(0, duty);
         run_frame(0, -5, 8'h0, 32'h0, hi, f, s);
         check_frame($sformatf("R11 sweep k%0d", k), 0, duty, hi, f, s);
         check("R5 full duty ch1 k0", (k == 0) ? hi[1] : 256, 256);
      end

      // R2 R6: prescaler sweep, both nibbles
      for (int p = 0; p < 5; p++) begin
         duty = '{0, 255, 9, 130};
         start(pss[p], duty);
         run_frame(pss[p], -5, 8'h0, 32'h0, hi, f, s);
         check_frame($sformatf("R2 R6 ps%0d", pss[p]), pss[p], duty, hi, f, s);
         check("R5 full frame", hi[1], 256*(pss[p]+1));
      end

      // R8: mid-frame writes deferred to frame boundary
      duty = '{200, 10, 0, 255};
      start(0, duty);
      run_frame(0, 40, 8'h00, 32'd20, hi, f, s);
      check_frame("R8 frame1 old duty", 0, duty, hi, f, s);
      duty = '{20, 10, 0, 255};
      run_frame(0, 40, CTRL, ctrl_word(1'b1, 2), hi, f, s);
      check_frame("R8 frame2 new duty old ps", 0, duty, hi, f, s);
      run_frame(2, -5, 8'h0, 32'h0, hi, f, s);
      check_frame("R8 frame3 new ps", 2, duty, hi, f, s);

      // R10: unmapped writes ignored
      duty = '{3, 77, 150, 250};
      start(0, duty);
      wr(8'h10, 32'hFFFF_FFFF);
      wr(8'h4C, 32'hFFFF_FFFF);
      wr(8'h51, 32'hFFFF_FFFF);
      wr(8'h54, 32'hFFFF_FFFF);
      wr(8'h02, 32'hFFFF_FFFF);
      wr(CTRL, ctrl_word(1'b0, 0));
      wr(CTRL, ctrl_word(1'b1, 0));
      run_frame(0, -5, 8'h0, 32'h0, hi, f, s);
      check_frame("R10 unmapped", 0, duty, hi, f, s);

      // R7: only low byte of duty kept
      wr(8'h04, 32'hFFFF_FF05);
      wr(8'h0C, 32'h0000_0100);
      wr(CTRL, ctrl_word(1'b0, 0));
      wr(CTRL, ctrl_word(1'b1, 0));
      duty = '{3, 5, 150, 0};
      run_frame(0, -5, 8'h0, 32'h0, hi, f, s);
      check_frame("R7 low byte", 0, duty, hi, f, s);

      // R9: disable forces low, enable restarts
      duty = '{255, 255, 255, 255};
      start(0, duty);
      repeat (7) @(negedge clk);
      wr(CTRL, ctrl_word(1'b0, 0));
      @(negedge clk);
      check("R9 low after disable", int'(pwm_out), 0);
      repeat (5) @(negedge clk);
      check("R9 stays low", int'(pwm_out), 0);
      duty = '{255, 0, 1, 254};
      start(0, duty);
      run_frame(0, -5, 8'h0, 32'h0, hi, f, s);
      check_frame("R9 restart", 0, duty, hi, f, s);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule